// File: doc/BRIEF.md
# Thermal Fault Regulator Enable Controller

This block drives the enables of three power regulators, a first buck converter, a second buck converter and a linear regulator. A host sets them through a small register file on a plain parallel register bus. An over-temperature flag arrives already synchronized, with hysteresis applied upstream. When it rises, every regulator enable drops in the same cycle and a sticky fault bit latches. After that, the host cannot turn any regulator back on until it clears that bit.

The way the block recovers depends on the enable pin. If the pin is low when the over-temperature flag falls, the regulators stay off and the host must restore them by register writes. If the pin is high, the block runs its built-in power-up order by itself: first buck, then second buck, then the linear regulator, with a fixed gap of `SEQ_GAP` clock cycles between steps. In this case the fault bit stays set as a record of the event.

The host can also set the fault bit itself, and this acts exactly like a thermal event. A fault-present output tells the serial front end to withhold acknowledge while the event is being handled. The same register that holds the fault bit also selects the divider for the external sync clock and its coupling mode. All of these pins are plain level control and status pins with no handshake.

Top module: `thermal_en_ctrl`

## Requirements
- R1: Bit 0 of address 4 is the fault bit. It is set on every cycle in which `ot_flag` is high. It stays 1 until the host writes 0 to it while `ot_flag` is low.
- R2: Address 3 holds the host enable bits: bit 7 enables the first buck, bit 6 the second buck, bit 5 the linear regulator, and bit 4 all three. While the fault bit is 1, writes to address 3 leave these bits unchanged. Reading address 3 returns the stored bits 7:4, 0 in bit 3, and the live outputs in bits 2:0 (bit 0 first buck, bit 1 second buck, bit 2 linear regulator).
- R3: With no fault, `buck1_en` equals bit 7 OR bit 4, `buck2_en` equals bit 6 OR bit 4, and `ldo_en` equals bit 5 OR bit 4 of address 3, starting from the cycle after the write.
- R4: While `ot_flag` is high, all three enables are low combinationally in the same cycle. The host enable bits and any running sequence are cleared.
- R5: Writing 1 to the fault bit has the same effect as a thermal event. The enables are off from the next cycle, and `fault_present` is high for exactly that one cycle.
- R6: If `en_pin` is high in the cycle that ends a fault, the sequence starts at the next edge, and the fault bit remains 1. `buck1_en` rises at that edge, `buck2_en` rises `SEQ_GAP` cycles later, and `ldo_en` rises `SEQ_GAP` cycles after that.
- R7: If `en_pin` is low when a fault ends, all enables stay off. After the host clears the fault bit, a write to address 3 takes effect again.
- R8: A rising edge on `en_pin` starts the same sequence when the fault bit is 0. The edge is ignored while the fault bit is 1.
- R9: In address 4, bit 6 alone gives `sync_div` = 1 (divide by 3), bit 5 alone gives 2 (divide by 6), and both set or both clear give 0 (no division). Bit 4 drives `sync_ac`. Reading address 4 returns bits 6:4 and the fault bit, with all other bits 0.
- R10: `fault_present` is high while `ot_flag` is high. After the flag falls, it stays high until the recovery cycle.
- R11: After reset, all registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ot_flag | input | 1 | Synchronized over-temperature flag, with hysteresis applied upstream |
| en_pin | input | 1 | Enable pin, synchronized |
| buck1_en | output | 1 | First buck converter enable |
| buck2_en | output | 1 | Second buck converter enable |
| ldo_en | output | 1 | Linear regulator enable |
| fault_present | output | 1 | Thermal event in progress; the front end withholds acknowledge |
| sync_div | output | 2 | Sync divider select: 0 none, 1 divide by 3, 2 divide by 6 |
| sync_ac | output | 1 | Sync input coupling: 1 AC, 0 DC |

## Verification
The bench builds the block with `SEQ_GAP` = 3 and `ADDR_W` = 3. With that setting, every rising edge of the power-up order can be checked cycle by cycle against a computed timeline within ten clocks. The bench sweeps all sixteen enable-bit patterns and all eight sync-select patterns, comparing them with values derived arithmetically. It recovers through both enable-pin paths and through the forced fault.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int unsigned CTL_ADDR = 3;
  localparam int unsigned OPS_ADDR = 4;
  localparam int unsigned DATA_W   = 8;

  typedef enum logic [1:0] {
    DIV_NONE = 2'd0,
    DIV_BY3  = 2'd1,
    DIV_BY6  = 2'd2
  } div_sel_e;
endpackage

// File: rtl/tfc_fault_latch.sv
module tfc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_flag,
  input  logic host_wr,
  input  logic host_val,
  output logic fault_bit,
  output logic fault_evt,
  output logic pending,
  output logic recover
);
  logic forced;

  assign forced    = host_wr & host_val;
  assign fault_evt = ot_flag | forced;
  assign recover   = pending & ~ot_flag & ~forced;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_bit <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (ot_flag)      fault_bit <= 1'b1;
      else if (host_wr) fault_bit <= host_val;
      if (fault_evt)    pending <= 1'b1;
      else if (recover) pending <= 1'b0;
    end
  end

  AST_OT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> fault_bit); // R1
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_bit && !ot_flag && !host_wr) |=> fault_bit); // R1
  AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_val && !ot_flag) |=> !fault_bit); // R1
endmodule

// File: rtl/tfc_reg_bank.sv
module tfc_reg_bank
  import tfc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fault_bit,
  input  logic              fault_evt,
  input  logic [2:0]        live_en,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        host_en,
  output logic              ops_wr,
  output logic              ops_fault_val,
  output logic [2:0]        sync_cfg
);
  logic ctl_wr;

  assign ctl_wr        = we && (addr == ADDR_W'(CTL_ADDR));
  assign ops_wr        = we && (addr == ADDR_W'(OPS_ADDR));
  assign ops_fault_val = wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_en  <= '0;
      sync_cfg <= '0;
    end else begin
      if (fault_evt)                host_en <= '0;
      else if (ctl_wr && !fault_bit) host_en <= wdata[7:4];
      if (ops_wr) sync_cfg <= wdata[6:4];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTL_ADDR))      rdata = {host_en, 1'b0, live_en};
    else if (addr == ADDR_W'(OPS_ADDR)) rdata = {1'b0, sync_cfg, 3'b000, fault_bit};
  end

  AST_LOCKED_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && fault_bit && !fault_evt) |=> (host_en == $past(host_en))); // R2
  AST_FAULT_CLEARS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (host_en == 4'b0000)); // R4
endmodule

// File: rtl/tfc_pwr_seq.sv
module tfc_pwr_seq #(
  parameter int unsigned SEQ_GAP = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  output logic [2:0] seq_en
);
  localparam int unsigned CW = (SEQ_GAP < 2) ? 1 : $clog2(SEQ_GAP);

  logic [1:0]    step;
  logic [CW-1:0] cnt;
  logic          stepping;

  assign stepping = (step == 2'd1) || (step == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      step   <= '0;
      cnt    <= '0;
      seq_en <= '0;
    end else if (start) begin
      step   <= 2'd1;
      cnt    <= '0;
      seq_en <= 3'b001;
    end else if (stepping) begin
      if (cnt == CW'(SEQ_GAP - 1)) begin
        cnt    <= '0;
        step   <= step + 2'd1;
        seq_en <= {seq_en[1:0], 1'b1};
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_en[1] && !seq_en[0]) && !(seq_en[2] && !seq_en[1])); // R6
  AST_SEQ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (seq_en == 3'b000)); // R4
endmodule

// File: rtl/thermal_en_ctrl.sv
module thermal_en_ctrl
  import tfc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEQ_GAP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ot_flag,
  input  logic              en_pin,
  output logic              buck1_en,
  output logic              buck2_en,
  output logic              ldo_en,
  output logic              fault_present,
  output logic [1:0]        sync_div,
  output logic              sync_ac
);
  logic       fault_bit, fault_evt, pending, recover;
  logic       ops_wr, ops_fault_val;
  logic [3:0] host_en;
  logic [2:0] sync_cfg, seq_en, live_en;
  logic       en_q, en_rise, seq_start;
  div_sel_e   div_sel;

  tfc_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .ot_flag(ot_flag),
    .host_wr(ops_wr), .host_val(ops_fault_val),
    .fault_bit(fault_bit), .fault_evt(fault_evt),
    .pending(pending), .recover(recover)
  );

  tfc_reg_bank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .fault_bit(fault_bit), .fault_evt(fault_evt), .live_en(live_en),
    .rdata(bus_rdata), .host_en(host_en), .ops_wr(ops_wr),
    .ops_fault_val(ops_fault_val), .sync_cfg(sync_cfg)
  );

  tfc_pwr_seq #(.SEQ_GAP(SEQ_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .abort(fault_evt), .seq_en(seq_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_pin;
  end

  assign en_rise   = en_pin & ~en_q;
  assign seq_start = (recover & en_pin) | (en_rise & ~fault_bit);

  assign buck1_en = (host_en[3] | host_en[0] | seq_en[0]) & ~ot_flag;
  assign buck2_en = (host_en[2] | host_en[0] | seq_en[1]) & ~ot_flag;
  assign ldo_en   = (host_en[1] | host_en[0] | seq_en[2]) & ~ot_flag;
  assign live_en  = {ldo_en, buck2_en, buck1_en};

  assign fault_present = ot_flag | pending;

  always_comb begin
    unique case (sync_cfg[2:1])
      2'b10:   div_sel = DIV_BY3;
      2'b01:   div_sel = DIV_BY6;
      default: div_sel = DIV_NONE;
    endcase
  end
  assign sync_div = div_sel;
  assign sync_ac  = sync_cfg[0];

  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ot_flag && en_pin && !fault_evt) |=> buck1_en); // R6
  AST_PRESENT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_present) |-> !ot_flag); // R10
  AST_RESTART_KEEPS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ot_flag && !ops_wr) |=> fault_bit); // R6
endmodule

// File: tb/thermal_en_ctrl_test.sv
module thermal_en_ctrl_test;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ot_flag = 1'b0;
  logic       en_pin = 1'b0;
  logic       buck1_en, buck2_en, ldo_en, fault_present, sync_ac;
  logic [1:0] sync_div;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  thermal_en_ctrl #(.ADDR_W(3), .SEQ_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ot_flag(ot_flag),
    .en_pin(en_pin), .buck1_en(buck1_en), .buck2_en(buck2_en), .ldo_en(ldo_en),
    .fault_present(fault_present), .sync_div(sync_div), .sync_ac(sync_ac)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] outs();
    return {5'b0, ldo_en, buck2_en, buck1_en};
  endfunction

  // cycle i after the start edge (i = 1 is the start edge)
  task automatic seq_run(input string req);
    for (int i = 1; i <= 2 * GAP + 2; i++) begin
      @(negedge clk);
      chk(req, outs(), {5'b0, 1'(i >= 1 + 2 * GAP), 1'(i >= 1 + GAP), 1'b1});
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk("R11 outs", outs(), 8'h00);
    chk("R11 present", {7'b0, fault_present}, 8'h00);
    chk("R11 sync", {5'b0, sync_ac, sync_div}, 8'h00);
    rd(3'd3, d); chk("R11 addr3", d, 8'h00);
    rd(3'd4, d); chk("R11 addr4", d, 8'h00);

    // R3/R2 sweep of all enable patterns
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pv;
      logic [2:0] e;
      pv = 4'(p);
      e = {pv[1] | pv[0], pv[2] | pv[0], pv[3] | pv[0]};
      wr(3'd3, {pv, 4'h0});
      chk("R3 enables", outs(), {5'b0, e});
      rd(3'd3, d); chk("R2 readback", d, {pv, 1'b0, e});
    end
    wr(3'd3, 8'h00);

    // R9 sweep of sync select
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vv;
      logic [1:0] ed;
      vv = 3'(v);
      ed = (vv[2] && !vv[1]) ? 2'd1 : ((vv[1] && !vv[2]) ? 2'd2 : 2'd0);
      wr(3'd4, {1'b0, vv, 4'h0});
      chk("R9 div", {6'b0, sync_div}, {6'b0, ed});
      chk("R9 ac", {7'b0, sync_ac}, {7'b0, vv[0]});
      rd(3'd4, d); chk("R9 readback", d, {1'b0, vv, 4'h0});
    end
    wr(3'd4, 8'h00);

    // R5/R7 forced fault, enable pin low
    wr(3'd3, 8'hF0);
    chk("R3 all on", outs(), 8'h07);
    wr(3'd4, 8'h01);
    chk("R5 off", outs(), 8'h00);
    chk("R5 present", {7'b0, fault_present}, 8'h01);
    @(negedge clk);
    chk("R5 present one cycle", {7'b0, fault_present}, 8'h00);
    repeat (2 * GAP + 2) @(negedge clk);
    chk("R7 stays off", outs(), 8'h00);
    rd(3'd4, d); chk("R1 fault read", d, 8'h01);
    wr(3'd3, 8'hF0);
    chk("R2 locked outs", outs(), 8'h00);
    rd(3'd3, d); chk("R2 locked bits", d, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h80);
    chk("R7 host restore", outs(), 8'h01);

    // R4/R10/R7 thermal event, enable pin low
    wr(3'd3, 8'hF0);
    @(negedge clk);
    ot_flag = 1'b1;
    #1 chk("R4 immediate off", outs(), 8'h00);
    chk("R10 present", {7'b0, fault_present}, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R1 ot overrides clear", d, 8'h01);
    @(negedge clk);
    ot_flag = 1'b0;
    #1 chk("R10 present after fall", {7'b0, fault_present}, 8'h01);
    @(negedge clk);
    chk("R10 present ends", {7'b0, fault_present}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 no auto restart", outs(), 8'h00);
    rd(3'd3, d); chk("R4 host bits cleared", d, 8'h00);
    rd(3'd4, d); chk("R1 sticky", d, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R1 host clear", d, 8'h00);

    // R8 enable pin rise starts sequence
    @(negedge clk);
    en_pin = 1'b1;
    seq_run("R8 pin sequence");

    // R6 thermal event with enable pin high
    @(negedge clk);
    ot_flag = 1'b1;
    #1 chk("R4 off during seq", outs(), 8'h00);
    repeat (2) @(negedge clk);
    ot_flag = 1'b0;
    seq_run("R6 auto sequence");
    rd(3'd4, d); chk("R6 fault kept", d, 8'h01);

    // R5/R6 forced fault with enable pin high
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h01);
    chk("R5 forced off", outs(), 8'h00);
    seq_run("R6 forced sequence");

    // R8 pin rise ignored while fault bit set
    en_pin = 1'b0;
    @(negedge clk);
    ot_flag = 1'b1;
    @(negedge clk);
    ot_flag = 1'b0;
    repeat (2) @(negedge clk);
    en_pin = 1'b1;
    repeat (2 * GAP + 3) @(negedge clk);
    chk("R8 rise ignored", outs(), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule